// File: doc/BRIEF.md
# Prioritized Interrupt Latch and Vector Unit

This unit collects interrupt requests and returns one 16-bit vector address to the processor. The requests come from five fixed-priority system sources, two external pins and eleven peripheral flags. The processor answers each request with a one-cycle service acknowledge. Both pins are active low and pass through a synchronizer. The non-maskable-style pin is always level sensitive and is gated only by the X mask. The other pin can be level sensitive or falling-edge sensitive. In edge mode a qualified edge is held in an internal latch until that request is serviced. The pin is gated by the I mask and its own enable. Each peripheral flag has its own enable and is gated by the I mask.

Arbitration uses a fixed order. A small elevation register can lift any one maskable source to the head of the maskable group. It holds the low byte of that source's vector. When arbitration grants a request, the vector is registered and held until the acknowledge. If a level-sensitive request is withdrawn during that window, the unit switches the vector to the trap address 0xFFF8. The processor then never enters a handler whose source has gone away.

Top module: `intr_vector_unit`

## Requirements
- R1: Fixed priority and vectors, highest first: `fixed_req[0]` 0xFFFE, `fixed_req[1]` 0xFFFC, `fixed_req[2]` 0xFFFA, `fixed_req[3]` 0xFFF8, `fixed_req[4]` 0xFFF6, the X pin 0xFFF4, then the maskable group. No mask bit blocks the five fixed sources.
- R2: The X pin (`xirq_pin_n`, low = request) is level sensitive and is granted only while `x_mask` is 0. `i_mask` has no effect on it.
- R3: The maskable group is the I pin (0xFFF2) and peripheral flag j (0xFFF0 − 2·j, j = 0..10). Nothing in this group is granted while `i_mask` is 1. Flag j is granted only when `periph_en[j]` is 1, and the I pin only when `irq_local_en` is 1.
- R4: With `irq_edge_sel` = 0 the I pin is level sensitive. With `irq_edge_sel` = 1, a high-to-low change sets the edge latch only if two consecutive synchronized samples are low. A low pulse lasting one clock is ignored.
- R5: The edge latch clears when a grant of 0xFFF2 made in edge mode is acknowledged. It then raises no further request until a new edge arrives.
- R6: The elevation register resets to 0xF2. When it holds the low byte of a maskable vector, that source outranks the rest of the maskable group. Sources outside the group keep their place above it. The remaining maskable sources keep their natural order.
- R7: A write to the elevation register whose value is odd, above 0xF2 or below 0xDC is ignored. The previous elevation stays in force.
- R8: `int_pending` rises with the registered vector one clock after a request is seen while idle. The vector then stays unchanged until `svc_ack`, whatever new requests arrive, and `int_pending` falls on the clock that takes the acknowledge. Arbitration resumes on the following clock.
- R9: If the held grant is the X pin, or the I pin in level mode, and the synchronized pin returns high before the acknowledge, the held vector becomes 0xFFF8.
- R10: After reset `int_pending` is 0 and `int_vector` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Maskable external request pin, active low |
| xirq_pin_n | input | 1 | X-masked external request pin, active low, level only |
| irq_edge_sel | input | 1 | 1 = falling-edge mode for irq_pin_n, 0 = level mode |
| irq_local_en | input | 1 | Local enable for irq_pin_n |
| i_mask | input | 1 | Global mask for the maskable group |
| x_mask | input | 1 | Mask for xirq_pin_n |
| fixed_req | input | 5 | Unmaskable system requests, bit 0 highest |
| periph_flag | input | 11 | Peripheral flag requests |
| periph_en | input | 11 | Per-flag local enables |
| elev_wr | input | 1 | Write strobe for the elevation register |
| elev_wdata | input | 8 | Vector low byte to elevate |
| svc_ack | input | 1 | One-cycle service acknowledge |
| int_pending | output | 1 | A granted vector is waiting for service |
| int_vector | output | 16 | Granted vector address |

## Verification
Two events can land in the same hold window: a higher-priority request arriving while a lower-priority grant waits, and the withdrawal of a level request before its acknowledge. The bench raises the top fixed request under a held timer vector. It expects the held vector to stay unchanged and the new request to be granted only after the acknowledge. It then releases the X pin during its own hold and expects the vector to switch to 0xFFF8. A scoreboard also confirms that requests raised together under masks come out in priority order, both with and without elevation.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int NFIX = 5;
    localparam logic [7:0]  MASK_TOP = 8'hF2;
    localparam logic [15:0] VEC_TRAP = 16'hFFF8;
    localparam logic [15:0] VEC_XPIN = 16'hFFF4;

    typedef enum logic {ST_IDLE, ST_HOLD} unit_state_e;
    typedef enum logic [1:0] {HK_OTHER, HK_XPIN, HK_IPIN_LVL, HK_IPIN_EDGE} held_kind_e;

    function automatic logic [15:0] fixed_vec(input int i);
        return 16'hFFFE - 16'(2 * i);
    endfunction

    function automatic logic [15:0] mask_vec(input int k);
        return {8'hFF, MASK_TOP - 8'(2 * k)};
    endfunction
endpackage

// File: rtl/intr_pin_sync.sv
module intr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic lvl_low,
    output logic fall_held
);
    localparam int W = STAGES + 2;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    // newest synchronized sample, then two history samples
    assign lvl_low   = !sh_q[STAGES-1];
    assign fall_held = !sh_q[STAGES-1] && !sh_q[STAGES] && sh_q[STAGES+1];
endmodule

// File: rtl/intr_elev_reg.sv
module intr_elev_reg
    import intr_pkg::*;
#(
    parameter int NM = 12,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [IW-1:0] elev_idx
);
    localparam logic [7:0] LOW_BYTE = MASK_TOP - 8'(2 * (NM - 1));

    logic [7:0] q_d, q_q;
    logic       wr_ok;

    always_comb begin
        wr_ok = wr_en && !wr_data[0] && (wr_data <= MASK_TOP) && (wr_data >= LOW_BYTE);
        q_d   = wr_ok ? wr_data : q_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= MASK_TOP;
        else        q_q <= q_d;
    end

    logic [7:0] diff;
    assign diff     = MASK_TOP - q_q;
    assign elev_idx = IW'(diff >> 1);
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_pkg::*;
#(
    parameter int NM = 12,
    parameter int IW = 4
) (
    input  logic [NFIX-1:0] fixed_req,
    input  logic            xpin_req,
    input  logic [NM-1:0]   mask_req,
    input  logic [IW-1:0]   elev_idx,
    output logic            valid,
    output logic [15:0]     vec,
    output logic            win_xpin,
    output logic            win_ipin
);
    logic [IW-1:0] win;

    always_comb begin
        win = '0;
        for (int k = NM - 1; k >= 0; k--) begin
            if (mask_req[k]) win = IW'(k);
        end
        if (int'(elev_idx) < NM && mask_req[elev_idx]) win = elev_idx;

        valid    = 1'b0;
        vec      = '0;
        win_xpin = 1'b0;
        win_ipin = 1'b0;
        if (|mask_req) begin
            valid    = 1'b1;
            vec      = mask_vec(int'(win));
            win_ipin = (win == '0);
        end
        if (xpin_req) begin
            valid    = 1'b1;
            vec      = VEC_XPIN;
            win_xpin = 1'b1;
            win_ipin = 1'b0;
        end
        for (int i = NFIX - 1; i >= 0; i--) begin
            if (fixed_req[i]) begin
                valid    = 1'b1;
                vec      = fixed_vec(i);
                win_xpin = 1'b0;
                win_ipin = 1'b0;
            end
        end
    end
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
    import intr_pkg::*;
#(
    parameter int N_PERIPH    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_pin_n,
    input  logic                xirq_pin_n,
    input  logic                irq_edge_sel,
    input  logic                irq_local_en,
    input  logic                i_mask,
    input  logic                x_mask,
    input  logic [4:0]          fixed_req,
    input  logic [N_PERIPH-1:0] periph_flag,
    input  logic [N_PERIPH-1:0] periph_en,
    input  logic                elev_wr,
    input  logic [7:0]          elev_wdata,
    input  logic                svc_ack,
    output logic                int_pending,
    output logic [15:0]         int_vector
);
    localparam int NM = N_PERIPH + 1;
    localparam int IW = $clog2(NM);

    typedef struct packed {
        unit_state_e st;
        logic [15:0] vec;
        held_kind_e  kind;
        logic        ipin_lat;
    } unit_regs_t;

    unit_regs_t cur_q, nxt_d;

    logic ipin_low, ipin_fall, xpin_low, xpin_fall_unused;
    logic [IW-1:0] elev_idx;
    logic ipin_req, xpin_req, arb_valid, arb_xpin, arb_ipin;
    logic [NM-1:0] mask_req;
    logic [15:0] arb_vec;

    intr_pin_sync #(.STAGES(SYNC_STAGES)) u_ipin (
        .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n),
        .lvl_low(ipin_low), .fall_held(ipin_fall)
    );

    intr_pin_sync #(.STAGES(SYNC_STAGES)) u_xpin (
        .clk(clk), .rst_n(rst_n), .pin_n(xirq_pin_n),
        .lvl_low(xpin_low), .fall_held(xpin_fall_unused)
    );

    intr_elev_reg #(.NM(NM), .IW(IW)) u_elev (
        .clk(clk), .rst_n(rst_n), .wr_en(elev_wr), .wr_data(elev_wdata),
        .elev_idx(elev_idx)
    );

    always_comb begin
        ipin_req = irq_local_en && (irq_edge_sel ? cur_q.ipin_lat : ipin_low);
        mask_req = i_mask ? '0 : {periph_flag & periph_en, ipin_req};
        xpin_req = xpin_low && !x_mask;
    end

    intr_arbiter #(.NM(NM), .IW(IW)) u_arb (
        .fixed_req(fixed_req), .xpin_req(xpin_req), .mask_req(mask_req),
        .elev_idx(elev_idx), .valid(arb_valid), .vec(arb_vec),
        .win_xpin(arb_xpin), .win_ipin(arb_ipin)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (arb_valid) begin
                    nxt_d.st  = ST_HOLD;
                    nxt_d.vec = arb_vec;
                    if (arb_xpin)      nxt_d.kind = HK_XPIN;
                    else if (arb_ipin) nxt_d.kind = irq_edge_sel ? HK_IPIN_EDGE : HK_IPIN_LVL;
                    else               nxt_d.kind = HK_OTHER;
                end
            end
            default: begin
                if (svc_ack) begin
                    nxt_d.st = ST_IDLE;
                    if (cur_q.kind == HK_IPIN_EDGE) nxt_d.ipin_lat = 1'b0;
                    nxt_d.kind = HK_OTHER;
                end else if ((cur_q.kind == HK_XPIN && !xpin_low) ||
                             (cur_q.kind == HK_IPIN_LVL && !ipin_low)) begin
                    nxt_d.vec  = VEC_TRAP;
                    nxt_d.kind = HK_OTHER;
                end
            end
        endcase
        if (ipin_fall && irq_edge_sel) nxt_d.ipin_lat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st       <= ST_IDLE;
            cur_q.vec      <= '0;
            cur_q.kind     <= HK_OTHER;
            cur_q.ipin_lat <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign int_pending = (cur_q.st == ST_HOLD);
    assign int_vector  = cur_q.vec;
endmodule

// File: rtl/intr_vector_unit_chk.sv
module intr_vector_unit_chk #(
    parameter int N_PERIPH = 11
) (
    input logic        clk,
    input logic        rst_n,
    input logic        i_mask,
    input logic        x_mask,
    input logic [4:0]  fixed_req,
    input logic        svc_ack,
    input logic        int_pending,
    input logic [15:0] int_vector
);
    localparam logic [15:0] LOWEST_VEC = 16'hFFF0 - 16'(2 * (N_PERIPH - 1));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pending && $past(int_pending) && !$past(svc_ack) && int_vector != 16'hFFF8)
        |-> (int_vector == $past(int_vector)));

    assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pending && svc_ack) |=> !int_pending);

    assert_imask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_pending) && int_vector[15:8] == 8'hFF && int_vector[7:0] <= 8'hF2)
        |-> !$past(i_mask));

    assert_xmask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_pending) && int_vector == 16'hFFF4) |-> !$past(x_mask));

    assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_pending) && $past(fixed_req[0])) |-> (int_vector == 16'hFFFE));

    assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_pending |-> (!int_vector[0] && int_vector >= LOWEST_VEC));
endmodule

bind intr_vector_unit intr_vector_unit_chk #(.N_PERIPH(N_PERIPH)) u_chk (
    .clk(clk), .rst_n(rst_n), .i_mask(i_mask), .x_mask(x_mask),
    .fixed_req(fixed_req), .svc_ack(svc_ack),
    .int_pending(int_pending), .int_vector(int_vector)
);

// File: tb/tb_intr_vector_unit.sv
module tb_intr_vector_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_pin_n = 1'b1, xirq_pin_n = 1'b1;
    logic irq_edge_sel = 1'b0, irq_local_en = 1'b1;
    logic i_mask = 1'b1, x_mask = 1'b1;
    logic [4:0] fixed_req = '0;
    logic [NP-1:0] periph_flag = '0, periph_en = '1;
    logic elev_wr = 1'b0;
    logic [7:0] elev_wdata = '0;
    logic svc_ack = 1'b0;
    logic int_pending;
    logic [15:0] int_vector;

    int checks = 0, errors = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    intr_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .xirq_pin_n(xirq_pin_n),
        .irq_edge_sel(irq_edge_sel), .irq_local_en(irq_local_en),
        .i_mask(i_mask), .x_mask(x_mask), .fixed_req(fixed_req),
        .periph_flag(periph_flag), .periph_en(periph_en),
        .elev_wr(elev_wr), .elev_wdata(elev_wdata), .svc_ack(svc_ack),
        .int_pending(int_pending), .int_vector(int_vector)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_drain();
        wait (exp_q.size() == 0);
        repeat (10) @(negedge clk);
    endtask

    task automatic write_elev(input logic [7:0] v);
        elev_wdata = v;
        elev_wr = 1'b1;
        @(negedge clk);
        elev_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
    endtask

    // emulated handler: clear the source belonging to the vector, then acknowledge
    task automatic serve(input logic [15:0] v);
        logic si, sx, lvl;
        int k;
        si = i_mask; sx = x_mask; lvl = 1'b0;
        if (v >= 16'hFFF6) begin
            k = (16'hFFFE - int'(v)) / 2;
            fixed_req[k] = 1'b0;
        end else if (v == 16'hFFF4) begin
            xirq_pin_n = 1'b1; x_mask = 1'b1; lvl = 1'b1;
        end else if (v == 16'hFFF2) begin
            irq_pin_n = 1'b1;
            if (!irq_edge_sel) begin i_mask = 1'b1; lvl = 1'b1; end
        end else begin
            k = (16'hFFF2 - int'(v)) / 2;
            periph_flag[k-1] = 1'b0;
        end
        pulse_ack();
        if (lvl) begin
            repeat (3) @(negedge clk);
            i_mask = si; x_mask = sx;
        end
    endtask

    // scoreboard monitor
    initial begin
        logic [15:0] e;
        string t;
        forever begin
            @(negedge clk);
            if (int_pending && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int_vector == e, t, int_vector, e);
                serve(int_vector);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!int_pending, "R10 pending after reset", {15'd0, int_pending}, 16'h0);
        check(int_vector == 16'h0, "R10 vector after reset", int_vector, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // all sources at once, default elevation (R1, R2, R6)
        push(16'hFFFE, "R1 order reset");
        push(16'hFFFC, "R1 order clock monitor");
        push(16'hFFFA, "R1 order watchdog");
        push(16'hFFF8, "R1 order trap");
        push(16'hFFF6, "R1 order swi");
        push(16'hFFF4, "R2 xpin after fixed");
        push(16'hFFF2, "R6 default ipin top of maskable");
        push(16'hFFE0, "R3 timer flag");
        fixed_req = 5'h1F;
        xirq_pin_n = 1'b0;
        irq_pin_n = 1'b0;
        periph_flag[8] = 1'b1;
        repeat (20) @(negedge clk);
        i_mask = 1'b0; x_mask = 1'b0;
        wait_drain();

        // masking (R2, R3)
        i_mask = 1'b1; x_mask = 1'b1;
        periph_flag[0] = 1'b1;
        xirq_pin_n = 1'b0;
        repeat (6) @(negedge clk);
        check(!int_pending, "R2 xpin blocked by x_mask", {15'd0, int_pending}, 16'h0);
        push(16'hFFF4, "R2 xpin ignores i_mask");
        x_mask = 1'b0;
        wait_drain();
        check(!int_pending, "R3 flag blocked by i_mask", {15'd0, int_pending}, 16'h0);
        periph_en[0] = 1'b0;
        i_mask = 1'b0;
        repeat (6) @(negedge clk);
        check(!int_pending, "R3 local enable off", {15'd0, int_pending}, 16'h0);
        push(16'hFFF0, "R3 local enable on");
        periph_en[0] = 1'b1;
        wait_drain();

        // elevation (R6)
        i_mask = 1'b1; x_mask = 1'b1;
        write_elev(8'hE6);
        push(16'hFFE6, "R6 elevated flag first");
        push(16'hFFF2, "R6 natural order after");
        push(16'hFFF0, "R6 natural order rti");
        push(16'hFFDE, "R6 natural order overflow");
        irq_pin_n = 1'b0;
        periph_flag[0] = 1'b1; periph_flag[5] = 1'b1; periph_flag[9] = 1'b1;
        repeat (6) @(negedge clk);
        i_mask = 1'b0; x_mask = 1'b0;
        wait_drain();

        // invalid writes ignored (R7)
        write_elev(8'hE7);
        write_elev(8'hDA);
        write_elev(8'hF4);
        i_mask = 1'b1;
        push(16'hFFE6, "R7 elevation kept");
        push(16'hFFF0, "R7 rest after");
        periph_flag[0] = 1'b1; periph_flag[5] = 1'b1;
        repeat (4) @(negedge clk);
        i_mask = 1'b0;
        wait_drain();
        write_elev(8'hF2);

        // edge mode (R4, R5)
        irq_edge_sel = 1'b1;
        i_mask = 1'b1;
        irq_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        irq_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!int_pending, "R4 edge latched but masked", {15'd0, int_pending}, 16'h0);
        push(16'hFFF2, "R4 edge latch grant");
        i_mask = 1'b0;
        wait_drain();
        check(!int_pending, "R5 latch cleared by ack", {15'd0, int_pending}, 16'h0);
        irq_pin_n = 1'b0;
        @(negedge clk);
        irq_pin_n = 1'b1;
        repeat (8) @(negedge clk);
        check(!int_pending, "R4 one-clock glitch ignored", {15'd0, int_pending}, 16'h0);
        irq_edge_sel = 1'b0;

        // hold against a new higher request (R8)
        periph_flag[8] = 1'b1;
        repeat (2) @(negedge clk);
        check(int_pending && int_vector == 16'hFFE0, "R8 timer granted", int_vector, 16'hFFE0);
        fixed_req[0] = 1'b1;
        repeat (3) @(negedge clk);
        check(int_vector == 16'hFFE0, "R8 vector held", int_vector, 16'hFFE0);
        periph_flag[8] = 1'b0;
        pulse_ack();
        check(!int_pending, "R8 pending drops on ack", {15'd0, int_pending}, 16'h0);
        @(negedge clk);
        check(int_pending && int_vector == 16'hFFFE, "R8 re-arbitrate after ack", int_vector, 16'hFFFE);
        fixed_req[0] = 1'b0;
        pulse_ack();
        repeat (3) @(negedge clk);

        // level withdrawn before ack (R9)
        xirq_pin_n = 1'b0;
        repeat (5) @(negedge clk);
        check(int_pending && int_vector == 16'hFFF4, "R9 xpin granted", int_vector, 16'hFFF4);
        xirq_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        check(int_pending && int_vector == 16'hFFF8, "R9 trap substituted", int_vector, 16'hFFF8);
        pulse_ack();
        repeat (4) @(negedge clk);
        check(!int_pending, "R9 idle after trap", {15'd0, int_pending}, 16'h0);

        finish_run();
    end
endmodule